// File: doc/BRIEF.md
# Grouped Prescaler and Binary Divider Tick Generator

This block turns one peripheral clock into five single-cycle tick enables, one for each channel of a five-channel timer. Two 8-bit prescaler counters run from the clock. The first paces channels 0 and 1 and the second paces channels 2, 3 and 4. Each channel then passes its group's prescaler strobe through its own power-of-two divider. A channel's tick rate is therefore the clock rate divided by (prescale + 1) times 2^select, and the divide saturates at 16.

Software loads the two configuration words through a single-cycle write port. A one-bit register select picks which word is loaded. Every write to the prescale word restarts both prescaler counts and every divider phase. This makes the tick pattern after that write fully predictable. The counters that consume the ticks sit outside this block. So do external clock sources and clock switching.

Top module: `timer_tick_gen`

## Requirements
- R1: While rst_ni is low, and in the cycle that follows its release, tick_o is all zero. Both prescale values and all select fields reset to 0, so after release every channel ticks on every cycle from the first clock edge onward.
- R2: Let n count the rising edges since the last prescale-word write or reset release. Channel c then asserts tick_o[c] exactly when n > 0 and n is a multiple of (P + 1) × D, where P is the channel's prescale value and D its divide.
- R3: A write with wr_sel_i = 0 loads prescale value 0 from wr_data_i[7:0] and prescale value 1 from wr_data_i[15:8]. Prescale value 0 paces channels 0 and 1. Prescale value 1 paces channels 2, 3 and 4.
- R4: A write with wr_sel_i = 1 loads the select field of channel c from wr_data_i[4c+3:4c]. A select value s from 0 to 4 gives a divide D = 2^s.
- R5: A select value of 5 to 15 gives a divide of 16.
- R6: Every write with wr_sel_i = 0 restarts both prescaler counts and clears all divider phases, even if the written values are unchanged.
- R7: In the cycle after a prescale-word write, tick_o is all zero, even if a tick was due at that edge.
- R8: Each tick is a one-cycle enable level on tick_o, updated on the rising clock edge. When (P + 1) × D > 1, a channel never ticks in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 1 | 0: prescale word, 1: divider select word |
| wr_data_i | input | 20 | Configuration write data |
| tick_o | output | 5 | Per-channel tick enables |

## Verification
Two events can fall in the same cycle: a prescale-word restart and a tick that is due at that same edge. The bench provokes this by holding both prescalers at 0 with a divide of 1, so a tick is due on every edge, and then writing the prescale word. It judges the result by requiring all-zero ticks in the cycle after the write and a clean period count from there. The sweep writes the divider word while the prescalers are still running and then writes the prescale word with the same or different values. This checks that the restart, and not the old phase, decides every later tick.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    REG_PRESCALE = 1'b0,
    REG_DIVSEL   = 1'b1
  } cfg_reg_e;

  function automatic int group_of(input int ch, input int grp0_ch);
    return (ch < grp0_ch) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
  import tick_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int NUM_GRP = 2,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int DATA_W  = 20
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             wr_sel_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_GRP-1:0][PRE_W-1:0]    pre_val_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
  output logic                             restart_o
);
  logic pre_wr, sel_wr;

  assign pre_wr    = wr_en_i && (wr_sel_i == REG_PRESCALE);
  assign sel_wr    = wr_en_i && (wr_sel_i == REG_DIVSEL);
  assign restart_o = pre_wr;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pre_val_o[g] <= '0;
      else if (pre_wr) pre_val_o[g] <= wr_data_i[g*PRE_W +: PRE_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_o[c] <= '0;
      else if (sel_wr) sel_o[c] <= wr_data_i[c*SEL_W +: SEL_W];
    end
  end

  // R3: a prescale-word write lands its field in the next cycle
  p_pre_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wr |=> (pre_val_o[0] == $past(wr_data_i[PRE_W-1:0])));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_val_i,
  input  logic             restart_i,
  output logic             pre_tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign pre_tick_o = (cnt_q == pre_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (pre_tick_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= pre_val_i);

  p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_tick_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = MAX_SEL;

  logic [CNT_W-1:0] cnt_q, mask;
  logic             tick_q;

  // bit i of the mask is set when the select exceeds i; saturates at MAX_SEL
  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (sel_i > SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (pre_tick_i) cnt_q <= cnt_q + 1'b1;
      tick_q <= pre_tick_i && ((cnt_q & mask) == mask);
    end
  end

  assign tick_o = tick_q;

  p_tick_after_pre_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(pre_tick_i));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && !tick_o));

  p_sat_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $stable(sel_i) && sel_i >= SEL_W'(MAX_SEL)) |-> (cnt_q == '0));
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import tick_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int GRP0_CH = 2,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 4,
  parameter int DATA_W  = (NUM_CH * SEL_W > 2 * PRE_W) ? NUM_CH * SEL_W : 2 * PRE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int NUM_GRP = 2;

  logic [NUM_GRP-1:0][PRE_W-1:0] pre_val;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel;
  logic                          restart;
  logic [NUM_GRP-1:0]            pre_tick;

  tick_cfg_regs #(
    .NUM_CH (NUM_CH),
    .NUM_GRP(NUM_GRP),
    .PRE_W  (PRE_W),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .pre_val_o(pre_val),
    .sel_o    (sel),
    .restart_o(restart)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tick_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_val_i (pre_val[g]),
      .restart_i (restart),
      .pre_tick_o(pre_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int G = group_of(c, GRP0_CH);
    tick_divider #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) i_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_tick_i(pre_tick[G]),
      .clear_i   (restart),
      .sel_i     (sel[c]),
      .tick_o    (tick_o[c])
    );
  end

  p_cfg_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == REG_PRESCALE) |=> (tick_o == '0));
endmodule

// File: tb/test_timer_tick_gen.sv
module test_timer_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 5;
  localparam int DATA_W = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NUM_CH-1:0] tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int p_cur[2];
  int s_cur[NUM_CH];

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_tick_gen i_timer_tick_gen (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .tick_o   (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int divide_of(input int s);
    return (s > 4) ? 16 : (1 << s);
  endfunction

  function automatic bit due(input int n, input int c);
    int per;
    per = (p_cur[(c < 2) ? 0 : 1] + 1) * divide_of(s_cur[c]);
    return (n > 0) && (n % per == 0);
  endfunction

  // caller is at a negedge; returns at the negedge after the write edge
  task automatic write_reg(input logic sel, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic observe(input int last_n);
    for (int n = 0; n <= last_n; n++) begin
      if (n > 0) @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) begin
        bit e;
        e = due(n, c);
        if (n == 0)
          check(tick[c] == 1'b0, $sformatf("R7 ch%0d n=0", c), tick[c], 0);
        else if (s_cur[c] > 4)
          check(tick[c] == e, $sformatf("R5 R2 ch%0d n=%0d", c, n), tick[c], e);
        else if (c < 2)
          check(tick[c] == e, $sformatf("R2 R3 R4 R8 ch%0d n=%0d", c, n), tick[c], e);
        else
          check(tick[c] == e, $sformatf("R2 R3 R4 R6 ch%0d n=%0d", c, n), tick[c], e);
      end
    end
  endtask

  task automatic run_cfg(input int p0, input int p1, input int k);
    logic [DATA_W-1:0] d;
    int mx;
    d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      s_cur[c] = (k + 3 * c) % 16;
      d[c*4 +: 4] = 4'(s_cur[c]);
    end
    write_reg(1'b1, d);
    // let the prescalers run with the new selects before the restart
    repeat (k % 3) @(negedge clk);
    p_cur[0] = p0; p_cur[1] = p1;
    write_reg(1'b0, DATA_W'({p1[7:0], p0[7:0]}));
    mx = (p0 > p1) ? p0 : p1;
    observe(2 * 16 * (mx + 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int pairs[5][2] = '{'{0, 1}, '{1, 0}, '{3, 2}, '{6, 4}, '{255, 2}};
    repeat (3) @(negedge clk);
    check(tick == '0, "R1 in reset", int'(tick), 0);
    rst_ni = 1'b1;
    p_cur[0] = 0; p_cur[1] = 0;
    for (int c = 0; c < NUM_CH; c++) s_cur[c] = 0;
    check(tick == '0, "R1 after release n=0", int'(tick), 0);
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      check(tick == '1, $sformatf("R1 defaults n=%0d", n), int'(tick), 31);
    end
    // collision: every channel is due on every edge when the restart lands
    write_reg(1'b0, '0);
    check(tick == '0, "R7 restart vs due tick", int'(tick), 0);
    for (int pi = 0; pi < 4; pi++)
      for (int k = 0; k < 16; k++)
        run_cfg(pairs[pi][0], pairs[pi][1], k);
    run_cfg(pairs[4][0], pairs[4][1], 7);
    // same values rewritten mid-period must still restart the phase
    repeat (5) @(negedge clk);
    write_reg(1'b0, DATA_W'({8'(p_cur[1]), 8'(p_cur[0])}));
    observe(2 * 16 * 256);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule